// File: doc/BRIEF.md
# Serial DAC Write Sequencer

This block drives an external serial digital-to-analog converter over a three-wire link made of a chip select, a serial clock and a data line. Each write sends one 16-bit command word, most significant bit first. The upper byte holds a 2-bit channel field, two mode bits that are always 1 (internal converter clock and bipolar output range) and the top four bits of a 12-bit value. The lower byte holds the low eight bits of the value.

A write can be started directly from the ports with a channel, a high byte and a low byte. A small list sequencer can also read a series of updates from a byte buffer outside the block, through a combinational read port. Byte 0 of the buffer holds the number of entries. Each entry that follows takes three bytes: the low value byte, the high value byte and a channel byte. The sequencer issues one converter write per entry, in buffer order.

Top module: `dac_list_writer`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the data line is low, and busy, the write-done pulse and the list-done pulse are all low.
- R2: Bits 15..14 of the word carry the channel and bits 13..12 are always 1. Bits 11..8 carry bits 3..0 of the supplied high byte. Bits 7..4 of the high byte never reach the word.
- R3: Bits 7..0 of the word carry the supplied low byte unchanged.
- R4: Each frame has exactly 16 rising serial-clock edges while chip select is low, and bit 15 goes out first. The data line changes only while the serial clock is low. The serial clock stays low whenever chip select is high.
- R5: Chip select stays low for the whole frame and rises one clock after the last falling serial-clock edge. The write-done pulse lasts one cycle and comes in the same cycle that chip select rises.
- R6: A direct start is ignored while busy is high. When a direct start and a list start arrive in the same cycle, the direct write is taken and the list start is ignored.
- R7: A list entry at buffer offset 1+3k holds the low byte, then the high byte, then the channel byte, whose bits 7..6 give the channel. Entries are written one frame each, in increasing k.
- R8: The list-done pulse lasts one cycle and comes exactly once per list, after the write-done of the last entry.
- R9: A list whose count byte is zero raises list-done without ever lowering chip select.
- R10: A count byte larger than MAX_ENTRIES is treated as MAX_ENTRIES.
- R11: Busy is high from the cycle after a start is accepted until the operation ends, and it is high whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | One-cycle pulse that starts a direct write |
| wr_chan | input | 2 | Channel for the direct write |
| wr_hi | input | 8 | High value byte; only bits 3..0 are used |
| wr_lo | input | 8 | Low value byte |
| lst_start | input | 1 | One-cycle pulse that starts the list sequencer |
| buf_addr | output | AW | Byte address into the update buffer |
| buf_data | input | 8 | Buffer byte at buf_addr, read combinationally |
| dac_cs_n | output | 1 | Converter chip select, active low |
| dac_sclk | output | 1 | Serial clock |
| dac_din | output | 1 | Serial data to the converter |
| busy | output | 1 | A write or a list is in progress |
| wr_done | output | 1 | One-cycle pulse at the end of each frame |
| lst_done | output | 1 | One-cycle pulse at the end of a list |

## Verification
The hardest cases to reach are the two collisions: a second direct start that lands in the middle of a frame, and a direct start and a list start asserted in the same cycle. The bench creates both by timing its stimulus from the busy output. It then checks that only one frame appears on the serial lines and that no list-done follows. The list corners are a zero count and a count above the entry limit. For these, the bench loads the buffer so that the entries past the limit would produce frames that are easy to spot.

// File: rtl/dacw_pkg.sv
package dacw_pkg;
   localparam int FRAME_W = 16;
   localparam int BIT_CW  = 4;

   typedef enum logic [1:0] {
      SH_IDLE,
      SH_LOW,
      SH_HIGH,
      SH_END
   } sh_state_t;

   typedef enum logic [2:0] {
      LS_IDLE,
      LS_COUNT,
      LS_LO,
      LS_HI,
      LS_CH,
      LS_GO,
      LS_WAIT
   } ls_state_t;
endpackage

// File: rtl/dacw_word_fmt.sv
module dacw_word_fmt #(
   parameter logic [1:0] MODE_BITS = 2'b11
) (
   input  logic [1:0]                   chan,
   input  logic [7:0]                   hi,
   input  logic [7:0]                   lo,
   output logic [dacw_pkg::FRAME_W-1:0] word
);
   logic [3:0] hi_nib;

   // upper half of the high byte is dropped before merging
   assign hi_nib = hi[3:0];
   assign word   = {chan, MODE_BITS, hi_nib, lo};
endmodule

// File: rtl/dacw_half_timer.sv
module dacw_half_timer #(
   parameter int HALF_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (HALF_CYC == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(HALF_CYC);
         localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);
         logic [CW-1:0] cnt;

         assign tick = run && (cnt == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!run || tick) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + CW'(1);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dacw_shifter.sv
module dacw_shifter #(
   parameter int HALF_CYC = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [dacw_pkg::FRAME_W-1:0] word,
   output logic                         cs_n,
   output logic                         sclk,
   output logic                         din,
   output logic                         busy,
   output logic                         done
);
   import dacw_pkg::*;

   localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(FRAME_W - 1);

   sh_state_t           state;
   logic [FRAME_W-1:0]  shreg;
   logic [BIT_CW-1:0]   bit_idx;
   logic                run;
   logic                tick;

   assign run  = (state == SH_LOW) || (state == SH_HIGH);
   assign busy = (state != SH_IDLE);

   dacw_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .tick (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SH_IDLE;
         shreg   <= '0;
         bit_idx <= '0;
         cs_n    <= 1'b1;
         sclk    <= 1'b0;
         din     <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            SH_IDLE: begin
               if (start) begin
                  shreg   <= word;
                  bit_idx <= '0;
                  cs_n    <= 1'b0;
                  sclk    <= 1'b0;
                  din     <= word[FRAME_W-1];
                  state   <= SH_LOW;
               end
            end
            SH_LOW: begin
               if (tick) begin
                  sclk  <= 1'b1;
                  state <= SH_HIGH;
               end
            end
            SH_HIGH: begin
               if (tick) begin
                  sclk <= 1'b0;
                  if (bit_idx == LAST_BIT) begin
                     state <= SH_END;
                  end else begin
                     bit_idx <= bit_idx + BIT_CW'(1);
                     shreg   <= {shreg[FRAME_W-2:0], 1'b0};
                     din     <= shreg[FRAME_W-2];
                     state   <= SH_LOW;
                  end
               end
            end
            default: begin
               cs_n  <= 1'b1;
               din   <= 1'b0;
               done  <= 1'b1;
               state <= SH_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/dacw_list_seq.sv
module dacw_list_seq #(
   parameter int MAX_ENTRIES = 8,
   parameter int AW          = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   output logic [AW-1:0] buf_addr,
   input  logic [7:0]    buf_data,
   input  logic          sh_done,
   output logic          sh_start,
   output logic [1:0]    e_chan,
   output logic [7:0]    e_hi,
   output logic [7:0]    e_lo,
   output logic          active,
   output logic          all_done
);
   import dacw_pkg::*;

   localparam int CW = $clog2(MAX_ENTRIES + 1);
   localparam logic [7:0]    MAX_B = 8'(MAX_ENTRIES);
   localparam logic [CW-1:0] MAX_C = CW'(MAX_ENTRIES);

   ls_state_t     state;
   logic [AW-1:0] ptr;
   logic [CW-1:0] remaining;

   assign buf_addr = ptr;
   assign sh_start = (state == LS_GO);
   assign active   = (state != LS_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= LS_IDLE;
         ptr       <= '0;
         remaining <= '0;
         e_chan    <= '0;
         e_hi      <= '0;
         e_lo      <= '0;
         all_done  <= 1'b0;
      end else begin
         all_done <= 1'b0;
         case (state)
            LS_IDLE: begin
               if (go) begin
                  ptr   <= '0;
                  state <= LS_COUNT;
               end
            end
            LS_COUNT: begin
               if (buf_data == 8'd0) begin
                  all_done <= 1'b1;
                  state    <= LS_IDLE;
               end else begin
                  remaining <= (buf_data > MAX_B) ? MAX_C : CW'(buf_data);
                  ptr       <= ptr + AW'(1);
                  state     <= LS_LO;
               end
            end
            LS_LO: begin
               e_lo  <= buf_data;
               ptr   <= ptr + AW'(1);
               state <= LS_HI;
            end
            LS_HI: begin
               e_hi  <= buf_data;
               ptr   <= ptr + AW'(1);
               state <= LS_CH;
            end
            LS_CH: begin
               e_chan <= buf_data[7:6];
               ptr    <= ptr + AW'(1);
               state  <= LS_GO;
            end
            LS_GO: begin
               state <= LS_WAIT;
            end
            default: begin
               if (sh_done) begin
                  if (remaining == CW'(1)) begin
                     all_done <= 1'b1;
                     state    <= LS_IDLE;
                  end else begin
                     remaining <= remaining - CW'(1);
                     state     <= LS_LO;
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/dac_list_writer.sv
module dac_list_writer #(
   parameter int         HALF_CYC    = 2,
   parameter int         MAX_ENTRIES = 8,
   parameter logic [1:0] MODE_BITS   = 2'b11,
   parameter int         AW          = $clog2(3 * MAX_ENTRIES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_start,
   input  logic [1:0]    wr_chan,
   input  logic [7:0]    wr_hi,
   input  logic [7:0]    wr_lo,
   input  logic          lst_start,
   output logic [AW-1:0] buf_addr,
   input  logic [7:0]    buf_data,
   output logic          dac_cs_n,
   output logic          dac_sclk,
   output logic          dac_din,
   output logic          busy,
   output logic          wr_done,
   output logic          lst_done
);
   import dacw_pkg::*;

   generate
      if (HALF_CYC < 1) begin : g_bad_half
         $error("HALF_CYC below 1");
      end
      if (MAX_ENTRIES < 1 || MAX_ENTRIES > 255) begin : g_bad_max
         $error("MAX_ENTRIES out of 1..255");
      end
      if ((1 << AW) < 3 * MAX_ENTRIES + 1) begin : g_bad_aw
         $error("AW too narrow for the list");
      end
   endgenerate

   logic               sh_busy;
   logic               sh_start;
   logic               sh_done;
   logic               seq_active;
   logic               seq_start;
   logic [1:0]         seq_chan;
   logic [7:0]         seq_hi;
   logic [7:0]         seq_lo;
   logic               accept_wr;
   logic               accept_lst;
   logic [1:0]         fmt_chan;
   logic [7:0]         fmt_hi;
   logic [7:0]         fmt_lo;
   logic [FRAME_W-1:0] word;

   assign busy       = sh_busy | seq_active;
   assign accept_wr  = wr_start & ~busy;
   assign accept_lst = lst_start & ~busy & ~wr_start;
   assign sh_start   = accept_wr | seq_start;

   assign fmt_chan = seq_start ? seq_chan : wr_chan;
   assign fmt_hi   = seq_start ? seq_hi   : wr_hi;
   assign fmt_lo   = seq_start ? seq_lo   : wr_lo;

   dacw_word_fmt #(.MODE_BITS(MODE_BITS)) u_fmt (
      .chan(fmt_chan),
      .hi  (fmt_hi),
      .lo  (fmt_lo),
      .word(word)
   );

   dacw_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
      .clk  (clk),
      .rst_n(rst_n),
      .start(sh_start),
      .word (word),
      .cs_n (dac_cs_n),
      .sclk (dac_sclk),
      .din  (dac_din),
      .busy (sh_busy),
      .done (sh_done)
   );

   dacw_list_seq #(.MAX_ENTRIES(MAX_ENTRIES), .AW(AW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (accept_lst),
      .buf_addr(buf_addr),
      .buf_data(buf_data),
      .sh_done (sh_done),
      .sh_start(seq_start),
      .e_chan  (seq_chan),
      .e_hi    (seq_hi),
      .e_lo    (seq_lo),
      .active  (seq_active),
      .all_done(lst_done)
   );

   assign wr_done = sh_done;
endmodule

// File: rtl/dac_list_writer_chk.sv
module dac_list_writer_chk (
   input logic clk,
   input logic rst_n,
   input logic dac_cs_n,
   input logic dac_sclk,
   input logic dac_din,
   input logic busy,
   input logic wr_done,
   input logic lst_done
);
   logic       sclk_q;
   logic [4:0] rise_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q   <= 1'b0;
         rise_cnt <= '0;
      end else begin
         sclk_q <= dac_sclk;
         if (dac_cs_n) begin
            rise_cnt <= '0;
         end else if (dac_sclk && !sclk_q) begin
            rise_cnt <= rise_cnt + 5'd1;
         end
      end
   end

   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      dac_cs_n |-> !dac_sclk); // R4

   AST_DIN_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_sclk && $past(dac_sclk)) |-> $stable(dac_din)); // R4

   AST_SIXTEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_cs_n) |-> (rise_cnt == 5'd16)); // R4

   AST_DONE_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> (dac_cs_n && !$past(dac_cs_n))); // R5

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wr_done); // R5

   AST_LIST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      lst_done |-> dac_cs_n); // R9

   AST_LIST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      lst_done |=> !lst_done); // R8

   AST_BUSY_COVERS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_cs_n |-> busy); // R11
endmodule

bind dac_list_writer dac_list_writer_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .dac_cs_n(dac_cs_n),
   .dac_sclk(dac_sclk),
   .dac_din (dac_din),
   .busy    (busy),
   .wr_done (wr_done),
   .lst_done(lst_done)
);

// File: tb/dac_list_writer_test.sv
module dac_list_writer_test;
   localparam int CLK_PERIOD = 10;
   localparam int MAXE       = 8;
   localparam int AW         = 5;
   localparam int WATCHDOG   = 150000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_start = 1'b0;
   logic [1:0]    wr_chan = '0;
   logic [7:0]    wr_hi = '0;
   logic [7:0]    wr_lo = '0;
   logic          lst_start = 1'b0;
   logic [AW-1:0] buf_addr;
   logic [7:0]    buf_data;
   logic          dac_cs_n, dac_sclk, dac_din, busy, wr_done, lst_done;

   logic [7:0] mem [0:(1<<AW)-1];

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [15:0] exp_q[$];
   logic [15:0] cap_word;
   int          cap_bits = 0;
   logic        prev_cs = 1'b1;
   logic        prev_sclk = 1'b0;
   int          frames = 0;
   int          lst_done_cnt = 0;
   int          frames_at_lst_done = 0;
   bit          cs_low_seen = 1'b0;
   bit          armed = 1'b0;

   assign buf_data = mem[buf_addr];

   always #(CLK_PERIOD/2) clk = ~clk;

   dac_list_writer #(.HALF_CYC(2), .MAX_ENTRIES(MAXE)) uut (
      .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_chan(wr_chan),
      .wr_hi(wr_hi), .wr_lo(wr_lo), .lst_start(lst_start),
      .buf_addr(buf_addr), .buf_data(buf_data), .dac_cs_n(dac_cs_n),
      .dac_sclk(dac_sclk), .dac_din(dac_din), .busy(busy),
      .wr_done(wr_done), .lst_done(lst_done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] model_word(input logic [1:0] ch,
                                              input logic [7:0] hi,
                                              input logic [7:0] lo);
      logic [15:0] w;
      w[15:14] = ch;
      w[13]    = 1'b1;
      w[12]    = 1'b1;
      w[11:8]  = hi[3:0];
      w[7:0]   = lo;
      return w;
   endfunction

   // reference monitor, evaluated on every falling clock edge
   always @(negedge clk) begin
      if (armed) begin
         if (dac_cs_n) begin
            check(!dac_sclk, "R4", "sclk with cs high", dac_sclk, 0);
         end else begin
            cs_low_seen = 1'b1;
            check(busy, "R11", "busy during frame", busy, 1);
         end
         if (!dac_cs_n && dac_sclk && !prev_sclk) begin
            cap_word = {cap_word[14:0], dac_din};
            cap_bits++;
         end
         if (dac_cs_n && !prev_cs) begin
            frames++;
            check(cap_bits == 16, "R4", "rising edges per frame", cap_bits, 16);
            check(wr_done, "R5", "done with cs rise", wr_done, 1);
            if (exp_q.size() == 0) begin
               check(1'b0, "R6", "unexpected frame", cap_word, 0);
            end else begin
               logic [15:0] e;
               e = exp_q.pop_front();
               check(cap_word == e, "R2", "frame word", cap_word, e);
            end
            cap_bits = 0;
         end else if (wr_done) begin
            check(1'b0, "R5", "done without cs rise", wr_done, 0);
         end
         if (lst_done) begin
            lst_done_cnt++;
            frames_at_lst_done = frames;
         end
         prev_cs   = dac_cs_n;
         prev_sclk = dac_sclk;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic direct_write(input logic [1:0] ch, input logic [7:0] hi,
                               input logic [7:0] lo);
      @(negedge clk);
      wr_chan = ch; wr_hi = hi; wr_lo = lo; wr_start = 1'b1;
      exp_q.push_back(model_word(ch, hi, lo));
      @(negedge clk);
      wr_start = 1'b0;
   endtask

   task automatic run_list(input int count, output int nframes, output int ndone,
                           output bit saw_cs);
      int f0, d0, n;
      f0 = frames; d0 = lst_done_cnt;
      cs_low_seen = 1'b0;
      mem[0] = 8'(count);
      n = (count > MAXE) ? MAXE : count;
      for (int k = 0; k < 10; k++) begin
         mem[1+3*k] = 8'(8'h13 + 8'h11 * k);
         mem[2+3*k] = 8'(8'hA0 | k);
         mem[3+3*k] = {2'(k), 6'h15};
         if (k < n) exp_q.push_back(model_word(2'(k), 8'(8'hA0 | k),
                                               8'(8'h13 + 8'h11 * k)));
      end
      @(negedge clk);
      lst_start = 1'b1;
      @(negedge clk);
      lst_start = 1'b0;
      while (lst_done_cnt == d0) @(negedge clk);
      wait_idle();
      nframes = frames - f0;
      ndone   = lst_done_cnt - d0;
      saw_cs  = cs_low_seen;
   endtask

   initial begin
      int nf, nd;
      bit sc;
      for (int i = 0; i < (1<<AW); i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(dac_cs_n == 1'b1, "R1", "cs_n", dac_cs_n, 1);
      check(dac_sclk == 1'b0, "R1", "sclk", dac_sclk, 0);
      check(dac_din == 1'b0, "R1", "din", dac_din, 0);
      check(busy == 1'b0 && wr_done == 1'b0 && lst_done == 1'b0, "R1", "status",
            {busy, wr_done, lst_done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      armed = 1'b1;

      // R2 R3: several patterns, high nibble masking
      direct_write(2'd0, 8'h05, 8'hA5); wait_idle();
      direct_write(2'd3, 8'hFF, 8'h00); wait_idle();
      direct_write(2'd1, 8'hF0, 8'hFF); wait_idle();
      direct_write(2'd2, 8'h3C, 8'h81); wait_idle();
      check(exp_q.size() == 0, "R3", "frames outstanding", exp_q.size(), 0);

      // R6: second start in mid-frame is ignored
      direct_write(2'd1, 8'h09, 8'h42);
      repeat (10) @(negedge clk);
      check(busy, "R11", "busy after accept", busy, 1);
      wr_chan = 2'd2; wr_hi = 8'h0E; wr_lo = 8'h77; wr_start = 1'b1;
      @(negedge clk);
      wr_start = 1'b0;
      wait_idle();
      check(exp_q.size() == 0 && frames == 5, "R6", "frames after busy start", frames, 5);

      // R6: direct start wins over list start in the same cycle
      mem[0] = 8'd2;
      begin
         int d0;
         d0 = lst_done_cnt;
         @(negedge clk);
         wr_chan = 2'd3; wr_hi = 8'h01; wr_lo = 8'h10;
         wr_start = 1'b1; lst_start = 1'b1;
         exp_q.push_back(model_word(2'd3, 8'h01, 8'h10));
         @(negedge clk);
         wr_start = 1'b0; lst_start = 1'b0;
         wait_idle();
         check(frames == 6 && exp_q.size() == 0, "R6", "collision frames", frames, 6);
         check(lst_done_cnt == d0, "R6", "list not started", lst_done_cnt, d0);
      end

      // R7 R8: list of three entries
      run_list(3, nf, nd, sc);
      check(nf == 3, "R7", "list frames", nf, 3);
      check(nd == 1, "R8", "list done count", nd, 1);
      check(frames_at_lst_done == frames, "R8", "done after last write",
            frames_at_lst_done, frames);
      check(exp_q.size() == 0, "R7", "list entries outstanding", exp_q.size(), 0);

      // R9: empty list
      run_list(0, nf, nd, sc);
      check(nf == 0, "R9", "empty list frames", nf, 0);
      check(!sc, "R9", "cs lowered on empty list", sc, 0);
      check(nd == 1, "R9", "empty list done", nd, 1);

      // R10: count above the limit is clamped
      run_list(10, nf, nd, sc);
      check(nf == MAXE, "R10", "clamped frames", nf, MAXE);
      check(nd == 1, "R8", "clamped list done", nd, 1);
      check(exp_q.size() == 0, "R10", "clamped outstanding", exp_q.size(), 0);

      // R7: single entry list then a direct write afterwards
      run_list(1, nf, nd, sc);
      check(nf == 1 && sc, "R7", "single entry frames", nf, 1);
      direct_write(2'd0, 8'h0F, 8'hFE); wait_idle();
      check(exp_q.size() == 0, "R5", "write after list", exp_q.size(), 0);
      check(dac_cs_n && !busy, "R11", "idle at end", {dac_cs_n, busy}, 2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule